// File: doc/BRIEF.md
# Lane Crossbar with Cached Routing Contexts

This block is an N-by-N matrix switch for W-bit data lanes. Input lanes run as rows and output lanes as columns. Each crosspoint stores one routing bit for each of K cached contexts. For every output column, the active context picks at most one input row to forward. A context register chooses which cached pattern is live. Software-free swizzling between a small set of recurring permutations therefore needs only a context change, with no reprogramming.

Patterns are written through the column buses themselves. While the program strobe is high, the outputs carry no valid data. The word present on each column's bus is read as a one-hot row code, and all N columns of the addressed context are written in a single cycle. A column code with more than one bit set is invalid. It is stored as an empty column and raises an error flag. Data outputs are registered, so they appear one cycle after the inputs are sampled.

Top module: `swizzleXbar`

## Requirements
- R1: After reset, all outputs read zero, the error flag reads 0, and every column of every context is empty.
- R2: At a clock edge where progEn is high, bits [N-1:0] of each column's cfgBus word are written into context progCtx for that column, where bit r selects input row r. Bits N to W-1 of the word are ignored.
- R3: In a program cycle, a column code with two or more bits set is stored as empty. progErr is then loaded with 1 if any column of that cycle was invalid and 0 otherwise, and it holds its value in cycles without programming.
- R4: After every edge at which progEn was high, outLanes reads all zero.
- R5: ctxSel is captured at a clock edge. Data sampled at the following edge is routed through the context that was captured.
- R6: An output column whose active-context entry is empty reads zero.
- R7: After an edge with progEn low, output lane c equals the input lane, sampled at that same edge, of the row selected for column c.
- R8: Programming one context leaves the contents of every other context unchanged.
- R9: Several output columns may select the same input row, and each of them receives a copy of that row's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inLanes | input | N*W | Input lanes; lane r occupies bits [r*W +: W] |
| cfgBus | input | N*W | Value driven onto the column buses in program mode; column c occupies bits [c*W +: W] |
| progEn | input | 1 | Program strobe; the outputs are blanked while it is high |
| progCtx | input | log2(K) | Context written in program mode |
| ctxSel | input | log2(K) | Context used for routing, registered |
| outLanes | output | N*W | Registered output lanes; column c occupies bits [c*W +: W] |
| progErr | output | 1 | Set when the last program cycle held an invalid column |

## Verification
The interesting collisions occur when a program write and a context switch land on the same edge, or when the context being written is also the one in use. The bench drives progEn together with a new ctxSel. It also reprograms the active context and then expects the very next data cycle to follow the new pattern. Expected outputs come from a per-cycle model in the bench that routes with the old contents and the old context before it applies either update. A random phase mixes both events freely and adds invalid and empty codes with noise in the upper bits.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  parameter int XB_PORTS = 8;
  parameter int XB_LANE_W = 16;
  parameter int XB_CTX = 4;
  localparam int XB_CTX_W = (XB_CTX > 1) ? $clog2(XB_CTX) : 1;

  // strobes from control to datapath
  typedef struct packed {
    logic                wrEn;
    logic [XB_CTX_W-1:0] wrCtx;
    logic [XB_CTX_W-1:0] rdCtx;
    logic                blankOut;
  } xbarCtl_t;
endpackage

// File: rtl/xbarCtrl.sv
module xbarCtrl
  import xbar_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                progEn,
  input  logic [XB_CTX_W-1:0] progCtx,
  input  logic [XB_CTX_W-1:0] ctxSel,
  input  logic                anyBad,
  output xbarCtl_t            ctl,
  output logic                progErr
);
  logic [XB_CTX_W-1:0] activeCtx;
  logic                errReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCtx <= '0;
      errReg    <= 1'b0;
    end else begin
      activeCtx <= ctxSel;
      if (progEn) errReg <= anyBad;
    end
  end

  always_comb begin
    ctl.wrEn     = progEn;
    ctl.wrCtx    = progCtx;
    ctl.rdCtx    = activeCtx;
    ctl.blankOut = progEn;
  end

  assign progErr = errReg;

  a_r5_ctx_capture: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ctl.rdCtx == $past(ctxSel));
  a_r3_err_set: assert property (@(posedge clk) disable iff (!rstN)
    progEn && anyBad |=> progErr);
  a_r3_err_clear: assert property (@(posedge clk) disable iff (!rstN)
    progEn && !anyBad |=> !progErr);
  a_r3_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    !progEn |=> $stable(progErr));
endmodule

// File: rtl/xbarDatapath.sv
module xbarDatapath
  import xbar_pkg::*;
#(
  parameter int N = XB_PORTS,
  parameter int W = XB_LANE_W,
  parameter int K = XB_CTX
) (
  input  logic         clk,
  input  logic         rstN,
  input  xbarCtl_t     ctl,
  input  logic [N*W-1:0] inLanes,
  input  logic [N*W-1:0] cfgBus,
  output logic [N*W-1:0] outLanes,
  output logic         anyBad
);
  logic [N-1:0] cfgMem [K][N];
  logic [N-1:0] colCode [N];
  logic [N-1:0] colBad;
  logic [W-1:0] routed [N];
  logic [N*W-1:0] outReg;

  // decode of each column bus and crosspoint storage
  for (genvar c = 0; c < N; c++) begin : g_col
    assign colCode[c] = cfgBus[c*W +: N];
    assign colBad[c]  = (colCode[c] & (colCode[c] - 1'b1)) != '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < K; k++) cfgMem[k][c] <= '0;
      end else if (ctl.wrEn) begin
        cfgMem[ctl.wrCtx][c] <= colBad[c] ? '0 : colCode[c];
      end
    end

    always_comb begin
      routed[c] = '0;
      for (int r = 0; r < N; r++)
        routed[c] = routed[c] | ({W{cfgMem[ctl.rdCtx][c][r]}} & inLanes[r*W +: W]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outReg[c*W +: W] <= '0;
      else       outReg[c*W +: W] <= ctl.blankOut ? '0 : routed[c];
    end

    a_r3_bad_stored_empty: assert property (@(posedge clk) disable iff (!rstN)
      ctl.wrEn && colBad[c] |=> cfgMem[$past(ctl.wrCtx)][c] == '0);
    a_r2_good_stored: assert property (@(posedge clk) disable iff (!rstN)
      ctl.wrEn && !colBad[c] |=> cfgMem[$past(ctl.wrCtx)][c] == $past(colCode[c]));
    a_r2_single_row: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(cfgMem[ctl.rdCtx][c]));
    a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.blankOut && cfgMem[ctl.rdCtx][c] == '0 |=> outLanes[c*W +: W] == '0);
  end

  assign anyBad   = |colBad;
  assign outLanes = outReg;

  a_r4_blank: assert property (@(posedge clk) disable iff (!rstN)
    ctl.blankOut |=> outLanes == '0);
endmodule

// File: rtl/swizzleXbar.sv
module swizzleXbar
  import xbar_pkg::*;
#(
  parameter int N = XB_PORTS,
  parameter int W = XB_LANE_W,
  parameter int K = XB_CTX
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N*W-1:0]      inLanes,
  input  logic [N*W-1:0]      cfgBus,
  input  logic                progEn,
  input  logic [XB_CTX_W-1:0] progCtx,
  input  logic [XB_CTX_W-1:0] ctxSel,
  output logic [N*W-1:0]      outLanes,
  output logic                progErr
);
  xbarCtl_t ctl;
  logic     anyBad;

  xbarCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .progEn(progEn), .progCtx(progCtx),
    .ctxSel(ctxSel), .anyBad(anyBad), .ctl(ctl), .progErr(progErr)
  );

  xbarDatapath #(.N(N), .W(W), .K(K)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inLanes(inLanes),
    .cfgBus(cfgBus), .outLanes(outLanes), .anyBad(anyBad)
  );
endmodule

// File: tb/swizzleXbar_tb.sv
`timescale 1ns/1ps
module swizzleXbar_tb;
  localparam int N = 8;
  localparam int W = 16;
  localparam int K = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N*W-1:0] inLanes = '0;
  logic [N*W-1:0] cfgBus = '0;
  logic progEn = 1'b0;
  logic [CW-1:0] progCtx = '0;
  logic [CW-1:0] ctxSel = '0;
  logic [N*W-1:0] outLanes;
  logic progErr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int refCfg [K][N];
  int refCtx;
  logic refErr;

  always #4 clk = ~clk;

  swizzleXbar u_dut (
    .clk(clk), .rstN(rstN), .inLanes(inLanes), .cfgBus(cfgBus),
    .progEn(progEn), .progCtx(progCtx), .ctxSel(ctxSel),
    .outLanes(outLanes), .progErr(progErr)
  );

  function automatic int decodeRow(input logic [W-1:0] word);
    int cnt = 0;
    int row = -1;
    for (int r = 0; r < N; r++)
      if (word[r]) begin cnt++; row = r; end
    return (cnt == 1) ? row : -1;
  endfunction

  function automatic bit isBad(input logic [W-1:0] word);
    int cnt = 0;
    for (int r = 0; r < N; r++) if (word[r]) cnt++;
    return cnt > 1;
  endfunction

  function automatic logic [N*W-1:0] expRoute(input int ctx, input logic [N*W-1:0] inV);
    logic [N*W-1:0] res = '0;
    for (int c = 0; c < N; c++)
      if (refCfg[ctx][c] >= 0) res[c*W +: W] = inV[refCfg[ctx][c]*W +: W];
    return res;
  endfunction

  function automatic logic [N*W-1:0] randLanes();
    logic [N*W-1:0] v;
    for (int i = 0; i < N*W/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [W-1:0] randCode();
    int kind = $urandom % 8;
    logic [W-1:0] w;
    w = W'($urandom) & ~W'((1 << N) - 1);
    if (kind == 1) w[N-1:0] = N'((1 << ($urandom % N)) | (1 << (($urandom % (N-1)) + 1)) | 1);
    else if (kind != 0) w[N-1:0] = N'(1 << ($urandom % N));
    return w;
  endfunction

  task automatic check(input string tag, input string what, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, check at next negedge
  task automatic step(input logic pe, input int pctx, input int csel,
                      input logic [N*W-1:0] inV, input logic [N*W-1:0] cfgV, input string tag);
    logic [N*W-1:0] expOut;
    bit bad = 0;
    progEn = pe; progCtx = CW'(pctx); ctxSel = CW'(csel); inLanes = inV; cfgBus = cfgV;
    expOut = pe ? '0 : expRoute(refCtx, inV);
    if (pe) begin
      for (int c = 0; c < N; c++) begin
        refCfg[pctx][c] = decodeRow(cfgV[c*W +: W]);
        if (isBad(cfgV[c*W +: W])) bad = 1;
      end
      refErr = bad;
    end
    refCtx = csel;
    @(posedge clk);
    @(negedge clk);
    check(tag, "outLanes", outLanes, expOut);
    check(tag, "progErr", {{(N*W-1){1'b0}}, progErr}, {{(N*W-1){1'b0}}, refErr});
  endtask

  function automatic logic [N*W-1:0] mkCfg(input int rows[N], input logic [W-1:0] noise);
    logic [N*W-1:0] v = '0;
    for (int c = 0; c < N; c++) begin
      v[c*W +: W] = noise & ~W'((1 << N) - 1);
      if (rows[c] >= 0) v[c*W + rows[c]] = 1'b1;
    end
    return v;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int idRows[N];
    int revRows[N];
    int bcRows[N];
    int mixRows[N];
    logic [N*W-1:0] cfgV;
    void'($urandom(32'd4242));
    for (int k = 0; k < K; k++) for (int c = 0; c < N; c++) refCfg[k][c] = -1;
    refCtx = 0; refErr = 1'b0;
    for (int c = 0; c < N; c++) begin
      idRows[c] = c; revRows[c] = N-1-c; bcRows[c] = 3; mixRows[c] = (c + 2) % N;
    end
    mixRows[0] = -1;

    repeat (3) @(negedge clk);
    check("R1", "reset outLanes", outLanes, '0);
    check("R1", "reset progErr", {{(N*W-1){1'b0}}, progErr}, '0);
    rstN = 1'b1;
    // R1: all contexts empty
    for (int k = 0; k < K; k++) step(0, 0, k, randLanes(), '0, "R1");
    step(0, 0, 0, randLanes(), '0, "R1");

    // R2 with upper-bit noise, R4 blank in program cycle
    step(1, 0, 0, randLanes(), mkCfg(idRows, 16'hA500), "R4");
    step(0, 0, 0, randLanes(), '0, "R2");
    step(0, 0, 0, randLanes(), '0, "R7");
    // R8: program ctx1 reversed, ctx0 untouched
    step(1, 1, 0, randLanes(), mkCfg(revRows, 16'hFF00), "R4");
    step(0, 0, 0, randLanes(), '0, "R8");
    // R5: switch to ctx1; first edge still uses ctx0
    step(0, 0, 1, randLanes(), '0, "R5");
    step(0, 0, 1, randLanes(), '0, "R5");
    // R9 broadcast
    step(1, 2, 2, randLanes(), mkCfg(bcRows, 16'h0000), "R9");
    step(0, 0, 2, {N{16'hBEEF}} ^ randLanes(), '0, "R9");
    // R3 invalid column plus R6 empty column
    cfgV = mkCfg(mixRows, 16'h0000);
    cfgV[1*W +: W] = 16'h0003;
    step(1, 3, 3, randLanes(), cfgV, "R3");
    step(0, 0, 3, randLanes(), '0, "R6");
    step(0, 0, 3, randLanes(), '0, "R3");
    step(1, 3, 3, randLanes(), mkCfg(idRows, 16'h1200), "R3");
    step(0, 0, 3, randLanes(), '0, "R3");
    // same-cycle: rewrite active ctx3 while switching to ctx0
    step(1, 3, 0, randLanes(), mkCfg(revRows, 16'h0000), "R5");
    step(0, 0, 3, randLanes(), '0, "R5");
    step(0, 0, 3, randLanes(), '0, "R2");
    step(0, 0, 1, randLanes(), '0, "R8");
    step(0, 0, 1, randLanes(), '0, "R8");

    // random mix of everything
    for (int i = 0; i < 3000; i++) begin
      logic pe = ($urandom % 6) == 0;
      cfgV = '0;
      for (int c = 0; c < N; c++) cfgV[c*W +: W] = randCode();
      step(pe, $urandom % K, $urandom % K, randLanes(), cfgV, "R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule